// File: doc/BRIEF.md
# Break Address Comparator with NMI Request

This block holds a bank of programmable break-address entries for a CPU with a 24-bit address bus and an 8-bit data bus. Software writes the entries through a 256-byte window at the very top of the address space. Every enabled entry is compared all the time against the live system address. When a bus cycle outside the window touches an address held in an enabled entry, the block raises a one-clock non-maskable interrupt request. The interrupt handler then finds out which service routine to run.

Each entry has four bytes. One byte carries the enable flag. The other three hold the compared address bits, at the same bit positions they have on the bus, so software stores an address without shifting it. The compared field is address bits 19 down to 2. A match therefore covers one aligned 4-byte group, anywhere inside a 1 MB span.

Top module: `break_nmi_unit`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, every entry is cleared, including its enable flag. After reset, `nmi_req` is 0 and every window byte reads 0.
- R2: The window covers 0xFFFF00 to 0xFFFFFF. Entry i starts at 0xFFFF00 + 4*i. The byte offsets within an entry are:
  - offset 0: enable, bit 7 (1 enables the entry)
  - offset 1: A19..A16, in bits 3..0
  - offset 2: A15..A8, in bits 7..0
  - offset 3: A7..A2, in bits 7..2
  
  A write takes effect on the clock edge where `bus_strobe` and `bus_wr` are both high and the address lies in the window.
- R3: `bus_rdata` shows the addressed byte combinationally while `bus_rd` is high and the address lies in the window. Bits with no storage read 0. `bus_rdata` is 0 when the address is outside the window and when `bus_rd` is low.
- R4: Window offsets 0x80 to 0xFF hold no entry. Writes to them change nothing, and reads from them return 0.
- R5: An enabled entry matches when bus bits A19..A2 equal its stored field. Bits A23..A20 and A1..A0 play no part in the match.
- R6: An entry whose enable bit is 0 never matches, whatever address it holds.
- R7: `nmi_req` is registered. It goes high for exactly one clock, in the cycle after the first cycle of a strobed bus access that matches. It stays low in every later cycle of that same access, however long `bus_strobe` is held.
- R8: An access whose address lies in the window never raises `nmi_req`, even when A19..A2 equal an enabled entry's field.
- R9: When several enabled entries match the same access, the block produces one single-clock `nmi_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 24 | System address bus |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Read data from the entry window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_strobe | input | 1 | Bus cycle / address valid |
| nmi_req | output | 1 | Non-maskable interrupt request, one clock per matching access |

## Verification
The hardest case to reach from the ports is an access that lies inside the register window and whose A19..A2 also equal an enabled entry's field. A random address almost never hits an exact 18-bit field and the 16-bit window prefix at the same moment. The bench reaches this case in a directed step: it stores 0xFFF00 in an entry, enables it, and then accesses 0xFFFF00, expecting no request, and 0x0FFF00, expecting one. The random phase points most of its accesses at the model's stored fields, with random A23..A20 and A1..A0, and holds the strobe for varying lengths. This exercises R5, R7 and R9 far more often than uniform addresses would.

// File: rtl/bac_pkg.sv
// bac_pkg
// Constants shared by the break-address comparator modules.
// Assumes a byte-wide data bus and entries of four bytes each.
// Address fields keep their bus bit positions, so the layout of each entry
// follows from CMP_HI/CMP_LO and needs no shifting.
package bac_pkg;
    localparam int ADDR_W      = 24;                   // system address width
    localparam int DATA_W      = 8;                    // data bus width
    localparam int ENTRY_BYTES = 4;                    // bytes per entry
    localparam int SEL_W       = $clog2(ENTRY_BYTES);  // byte-select width
    localparam int WIN_BITS    = 8;                    // window spans 2**WIN_BITS bytes
    localparam int CMP_HI      = 19;                   // top compared address bit
    localparam int CMP_LO      = 2;                    // bottom compared address bit
    localparam int CMP_W       = CMP_HI - CMP_LO + 1;  // compared field width
    localparam int EN_BIT      = 7;                    // enable flag position in byte 0
    localparam int EN_BYTE     = 0;                    // offset of the enable byte

    // Offset within an entry of the byte that holds address bit k.
    // Byte 3 holds bits 7..0, byte 2 bits 15..8, byte 1 bits 23..16.
    function automatic int byte_of_bit(input int k);
        return ENTRY_BYTES - 1 - (k / DATA_W);
    endfunction
endpackage

// File: rtl/bac_decode.sv
// bac_decode
// Decodes a bus address against the register window at the top of memory.
// Assumes the window fills the top 2**WIN_BITS bytes. Entries start at
// offset 0 and are packed with no gaps. Offsets past the last entry give
// in_window=1 and entry_ok=0.
module bac_decode #(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [bac_pkg::ADDR_W-1:0] addr,
    output logic                       in_window,
    output logic                       entry_ok,
    output logic [IDX_W-1:0]           entry_idx,
    output logic [bac_pkg::SEL_W-1:0]  byte_sel
);
    import bac_pkg::*;

    localparam int USED_BYTES = NUM_ENTRIES * ENTRY_BYTES;

    logic [WIN_BITS-1:0] offset;

    // Split the address into window hit, byte offset and entry fields.
    always_comb begin
        in_window = &addr[ADDR_W-1:WIN_BITS];
        offset    = addr[WIN_BITS-1:0];
        entry_ok  = in_window && (int'(offset) < USED_BYTES);
        byte_sel  = offset[SEL_W-1:0];
        entry_idx = offset[SEL_W +: IDX_W];
    end
endmodule

// File: rtl/bac_entry.sv
// bac_entry
// One break entry: the enable flag, the stored address field, byte-wise
// write and readback, and an equality comparator on bus bits CMP_HI..CMP_LO.
// Assumes the write select has already been qualified by decode and strobe.
module bac_entry (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [bac_pkg::SEL_W-1:0]    byte_sel,
    input  logic [bac_pkg::DATA_W-1:0]   wdata,
    input  logic [bac_pkg::CMP_W-1:0]    cmp_field,
    output logic [bac_pkg::DATA_W-1:0]   rd_byte,
    output logic                         enabled,
    output logic                         match
);
    import bac_pkg::*;

    logic             en_q;
    logic [CMP_W-1:0] fld_q;

    // Storage: clear on reset, otherwise load the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fld_q <= '0;
        end else if (wr_en) begin
            if (int'(byte_sel) == EN_BYTE) begin
                en_q <= wdata[EN_BIT];
            end
            for (int k = CMP_LO; k <= CMP_HI; k++) begin
                if (int'(byte_sel) == byte_of_bit(k)) begin
                    fld_q[k-CMP_LO] <= wdata[k % DATA_W];
                end
            end
        end
    end

    // Readback: place each stored bit at its bus position in its byte.
    always_comb begin
        rd_byte = '0;
        if (int'(byte_sel) == EN_BYTE) begin
            rd_byte[EN_BIT] = en_q;
        end
        for (int k = CMP_LO; k <= CMP_HI; k++) begin
            if (int'(byte_sel) == byte_of_bit(k)) begin
                rd_byte[k % DATA_W] = fld_q[k-CMP_LO];
            end
        end
    end

    // Comparator: the entry matches only while it is enabled.
    always_comb begin
        enabled = en_q;
        match   = en_q && (cmp_field == fld_q);
    end

    // R1
    en_reset_clr_chk: assert property (@(posedge clk)
        !rst_n |=> !en_q);

    // R2
    en_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(byte_sel) == EN_BYTE) |=> (en_q == $past(wdata[EN_BIT])));

    // R6
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (en_q == $past(en_q)));
endmodule

// File: rtl/bac_nmi.sv
// bac_nmi
// Combines the per-entry matches and times the interrupt request.
// Assumes bus_strobe stays high for the whole access. Only the first
// strobed cycle can trigger, and accesses to the window are excluded.
module bac_nmi #(
    parameter int NUM_ENTRIES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe,
    input  logic                   in_window,
    input  logic [NUM_ENTRIES-1:0] match_vec,
    output logic                   nmi_req
);
    logic strobe_q;
    logic any_match;
    logic fire;

    // OR of all entry matches, qualified by the start of an access.
    always_comb begin
        any_match = |match_vec;
        fire      = strobe && !strobe_q && !in_window && any_match;
    end

    // Register the strobe history and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            nmi_req  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            nmi_req  <= fire;
        end
    end

    // R7
    nmi_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R7
    nmi_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && strobe_q) |=> !nmi_req);

    // R8
    nmi_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && in_window) |=> !nmi_req);
endmodule

// File: rtl/break_nmi_unit.sv
// break_nmi_unit
// Top of the break-address comparator. It decodes the register window,
// instantiates one entry per break address, muxes readback and drives the
// registered NMI request.
// Assumes a single clock domain and bus signals synchronous to clk.
module break_nmi_unit #(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_strobe,
    output logic        nmi_req
);
    import bac_pkg::*;

    logic                   in_window;
    logic                   entry_ok;
    logic [IDX_W-1:0]       entry_idx;
    logic [SEL_W-1:0]       byte_sel;
    logic                   wr_any;
    logic [NUM_ENTRIES-1:0] match_vec;
    logic [NUM_ENTRIES-1:0] en_vec;
    logic [DATA_W-1:0]      rd_bytes [NUM_ENTRIES];

    bac_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_decode (
        .addr      (bus_addr),
        .in_window (in_window),
        .entry_ok  (entry_ok),
        .entry_idx (entry_idx),
        .byte_sel  (byte_sel)
    );

    // Qualified write: strobe and write on an address that holds an entry.
    always_comb wr_any = bus_strobe && bus_wr && entry_ok;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        logic wr_this;
        // Per-entry write select.
        always_comb wr_this = wr_any && (int'(entry_idx) == i);

        bac_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_this),
            .byte_sel  (byte_sel),
            .wdata     (bus_wdata),
            .cmp_field (bus_addr[CMP_HI:CMP_LO]),
            .rd_byte   (rd_bytes[i]),
            .enabled   (en_vec[i]),
            .match     (match_vec[i])
        );
    end

    // Readback mux: the addressed byte while reading, 0 otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && entry_ok) begin
            bus_rdata = rd_bytes[entry_idx];
        end
    end

    bac_nmi #(.NUM_ENTRIES(NUM_ENTRIES)) u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bus_strobe),
        .in_window (in_window),
        .match_vec (match_vec),
        .nmi_req   (nmi_req)
    );

    // R3
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && in_window) |-> (bus_rdata == '0));

    // R6
    match_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && (en_vec == '0)) |=> !nmi_req);

    // R7
    nmi_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(bus_strobe));
endmodule

// File: tb/sim_break_nmi_unit.sv
// sim_break_nmi_unit
// Self-checking bench: directed corner cases, then a seeded random mix of
// writes, reads and accesses, all compared against a behavioural model.
module sim_break_nmi_unit;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_strobe = 1'b0;
    logic        nmi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        en_m  [N];
    logic [17:0] fld_m [N];

    always #2.5 clk = ~clk;

    break_nmi_unit #(.NUM_ENTRIES(N)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_strobe (bus_strobe),
        .nmi_req    (nmi_req)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [23:0] a);
        return a[23:8] == 16'hFFFF;
    endfunction

    function automatic logic [7:0] exp_read(input logic [23:0] a);
        int off = int'(a[7:0]);
        int i = off / 4;
        if (!in_win(a) || off >= N * 4) return 8'h00;
        case (off % 4)
            0: return {en_m[i], 7'b0};
            1: return {4'b0, fld_m[i][17:14]};
            2: return fld_m[i][13:6];
            default: return {fld_m[i][5:0], 2'b0};
        endcase
    endfunction

    function automatic logic exp_nmi(input logic [23:0] a);
        if (in_win(a)) return 1'b0;
        for (int i = 0; i < N; i++)
            if (en_m[i] && fld_m[i] == a[19:2]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_write(input logic [23:0] a, input logic [7:0] d);
        int off = int'(a[7:0]);
        int i = off / 4;
        if (!in_win(a) || off >= N * 4) return;
        case (off % 4)
            0: en_m[i] = d[7];
            1: fld_m[i][17:14] = d[3:0];
            2: fld_m[i][13:6] = d;
            default: fld_m[i][5:0] = d[7:2];
        endcase
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_strobe = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_strobe = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [23:0] a, input logic rd, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_strobe = 1'b1;
        #1;
        chk(bus_rdata, rd ? exp_read(a) : 8'h00, tag);
        @(negedge clk);
        bus_rd = 1'b0; bus_strobe = 1'b0;
    endtask

    task automatic set_entry(input int i, input logic [23:0] a, input logic en);
        logic [23:0] base = 24'hFFFF00 + 24'(4 * i);
        bus_write(base + 24'd1, a[23:16]);
        bus_write(base + 24'd2, a[15:8]);
        bus_write(base + 24'd3, a[7:0]);
        bus_write(base, {en, 7'b0});
    endtask

    // Strobed access for len cycles; checks the single NMI pulse timing.
    task automatic access(input logic [23:0] a, input int len, input string tag);
        logic e = exp_nmi(a);
        @(negedge clk);
        bus_addr = a; bus_strobe = 1'b1;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            chk({7'b0, nmi_req}, {7'b0, (c == 0) ? e : 1'b0}, tag);
        end
        bus_strobe = 1'b0;
        @(negedge clk);
        chk({7'b0, nmi_req}, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd24601);
        for (int i = 0; i < N; i++) begin en_m[i] = 1'b0; fld_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        @(negedge clk);
        chk({7'b0, nmi_req}, 8'h00, "R1 nmi after reset");
        bus_read(24'hFFFF00, 1'b1, "R1 enable byte 0");
        bus_read(24'hFFFF7D, 1'b1, "R1 field byte 31");
        access(24'h000000, 1, "R1 no entry enabled");

        // R2/R3: layout and readback with unused bits zero.
        set_entry(0, 24'h012344, 1'b1);
        bus_write(24'hFFFF01, 8'hFF);
        bus_write(24'hFFFF03, 8'hFF);
        bus_read(24'hFFFF01, 1'b1, "R2 high byte bits 3:0 only");
        bus_read(24'hFFFF03, 1'b1, "R2 low byte bits 7:2 only");
        bus_write(24'hFFFF01, 8'h01);
        bus_write(24'hFFFF03, 8'h44);
        bus_read(24'hFFFF00, 1'b1, "R2 enable bit 7");
        bus_read(24'hFFFF02, 1'b1, "R2 mid byte");
        bus_read(24'hFFFF02, 1'b0, "R3 rd low reads 0");
        bus_read(24'h00FF02, 1'b1, "R3 outside window reads 0");

        // R5: match ignores A23..A20 and A1..A0.
        access(24'h012344, 1, "R5 exact hit");
        access(24'h012347, 1, "R5 low bits ignored");
        access(24'hA12344, 1, "R5 upper nibble ignored");
        access(24'h012348, 1, "R5 next group misses");

        // R6: disabled entry never matches.
        bus_write(24'hFFFF00, 8'h7F);
        access(24'h012344, 1, "R6 disabled entry");
        bus_write(24'hFFFF00, 8'h80);

        // R8: window access with matching field.
        set_entry(31, 24'h0FFF00, 1'b1);
        access(24'hFFFF00, 2, "R8 window access quiet");
        access(24'h0FFF00, 1, "R8 same field outside window");

        // R9 and R7: two entries on one address, long strobe.
        set_entry(5, 24'h3ABC10, 1'b1);
        set_entry(6, 24'h0ABC10, 1'b1);
        access(24'h5ABC12, 4, "R9 two matches one pulse");

        // R4: unused offsets ignore writes and read 0.
        bus_write(24'hFFFF80, 8'hFF);
        bus_write(24'hFFFFFF, 8'hFF);
        bus_read(24'hFFFF80, 1'b1, "R4 unused offset reads 0");
        bus_read(24'hFFFF00, 1'b1, "R4 entry 0 unchanged");
        bus_read(24'hFFFF7E, 1'b1, "R4 entry 31 unchanged");

        // Random mix checked against the model.
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 4) begin
                bus_write({16'hFFFF, 8'($urandom_range(0, 255))}, 8'($urandom));
            end else if (op < 6) begin
                bus_read({16'hFFFF, 8'($urandom_range(0, 255))}, 1'b1, "R3 random read");
            end else begin
                logic [23:0] a;
                if ($urandom_range(0, 3) != 0) begin
                    int i = $urandom_range(0, N - 1);
                    a = {4'($urandom), fld_m[i], 2'($urandom)};
                end else begin
                    a = 24'($urandom);
                end
                access(a, $urandom_range(1, 3), "R7 random access");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule